// File: doc/BRIEF.md
# Receive Descriptor Scatter Engine

This engine stores one received frame at a time into a ring of receive buffer descriptors held in system memory. A frame is announced by a header that carries its payload length and its 32-bit frame check value. The payload bytes then follow on a byte stream. The engine walks the ring ahead of the current descriptor to confirm that enough empty buffers exist. If they do, it spreads the payload across those buffers, then the check value. It writes back each descriptor with its byte count and status, and moves the ring pointer on. If they do not, it consumes the frame from the stream and stores nothing.

Each descriptor is two 32-bit words. Word 0 holds the status flags in bits 31:16 and the byte count in bits 15:0. Word 1 holds the word-aligned buffer address. The flags used are:

- empty: flag bit 15 (word bit 31)
- wrap: flag bit 13 (word bit 29)
- last: flag bit 11 (word bit 27)
- oversize: flag bit 5 (word bit 21)
- truncated: flag bit 0 (word bit 16)

Software arms reception with a pulse. The engine disarms itself when the ring runs into a descriptor that is not empty.

Top module: `rxsg_scatter`

## Requirements
- R1: After a synchronous reset, `rx_active` is 0, `cur_desc` is 0, no memory request is issued and `hdr_ready` is 1 while `din_ready` is 0.
- R2: `ring_init` loads `cur_desc` from `ring_base` and clears `rx_active`. `rx_arm` reads word 0 of the current descriptor and sets `rx_active` to its empty bit (word bit 31).
- R3: A header accepted while `rx_active` is 0 causes no memory write and no event. Its `hdr_len` payload bytes are still consumed from the stream.
- R4: The stored size is `hdr_len` + 4. A stored size above `MAX_STORE` is cut to `MAX_STORE`. In that case the final descriptor carries both the truncated flag (word bit 16) and the oversize flag (word bit 21), and the payload bytes beyond the cut are consumed and discarded.
- R5: A stored size greater than `max_frm_len` sets the oversize flag (word bit 21) in the final descriptor.
- R6: Before any write, the engine walks the ring from the current descriptor, taking `buf_size` off the remaining count at each step. It rejects the frame at the first descriptor whose empty bit is clear, and accepts once the remaining count is below `buf_size`. A remaining count exactly equal to `buf_size` therefore needs one more empty descriptor. A rejected frame writes nothing, raises no event and leaves `cur_desc` unchanged.
- R7: Each used buffer receives min(remaining, `buf_size`) bytes, and that value is written as the byte count. Bytes are packed big-endian: buffer byte 4n+0 goes to word bits 31:24. Byte enables are used, so the bytes past the count in a buffer stay untouched.
- R8: The 4 check-value bytes follow the payload most significant byte first, and may span two buffers.
- R9: Every used descriptor is written back with its empty bit cleared and its other flags kept. The final descriptor also gets the last flag (word bit 27) plus any error flags. The final descriptor pulses `ev_rx_frame` for one cycle, and every other used descriptor pulses `ev_rx_buf` for one cycle.
- R10: The descriptor after the current one is `ring_base` if the current descriptor's wrap bit (word bit 29) is set, and the current address + 8 otherwise. `cur_desc` moves past all used descriptors once a frame is stored.
- R11: After a stored frame, `rx_active` takes the empty bit of the new current descriptor.
- R12: A memory request held without `mem_ack` keeps the same address and direction in the next cycle.
- R13: `din_ready` is high only while payload bytes are being stored or discarded, never while a header can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | AW | Address of the first descriptor of the ring |
| buf_size | input | BUF_W | Bytes per receive buffer, nonzero |
| max_frm_len | input | 16 | Stored-size limit for the oversize flag |
| ring_init | input | 1 | Pulse: reload current descriptor from ring base, disarm |
| rx_arm | input | 1 | Pulse: arm reception from the current descriptor's empty bit |
| hdr_valid | input | 1 | Frame header valid |
| hdr_ready | output | 1 | Frame header accepted |
| hdr_len | input | LEN_W | Payload length in bytes, excluding the check value |
| hdr_crc | input | 32 | Frame check value to append |
| din_valid | input | 1 | Payload byte valid |
| din_ready | output | 1 | Payload byte accepted |
| din_data | input | 8 | Payload byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables, bit 3 is bits 31:24 |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| rx_active | output | 1 | Reception armed |
| cur_desc | output | AW | Current descriptor address |
| ev_rx_buf | output | 1 | Pulse: a non-final buffer was closed |
| ev_rx_frame | output | 1 | Pulse: a frame was completed |

## Verification
Two things can land on the same write-back. The final descriptor of a frame may also be the one that carries the wrap bit, so frame completion, the jump back to `ring_base` and the re-arming read of the base descriptor all follow from one descriptor update. The bench provokes this by keeping a four-entry ring whose last entry wraps and sweeping every payload length through it without re-initialising, so frames end on every ring position. Each case is judged by the written descriptor words, the buffer contents, the event counts, `cur_desc` and `rx_active`. All of these are computed arithmetically in the bench, while memory acknowledgements arrive with pseudo-random gaps.

// File: rtl/rxsg_pkg.sv
package rxsg_pkg;

    // descriptor flag positions inside the 16-bit status half
    localparam int FLG_EMPTY = 15;
    localparam int FLG_WRAP  = 13;
    localparam int FLG_LAST  = 11;
    localparam int FLG_LONG  = 5;
    localparam int FLG_TRUNC = 0;

    localparam int DESC_STRIDE = 8;
    localparam int CHK_BYTES   = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ARM,
        ST_CHECK,
        ST_GETFLG,
        ST_GETPTR,
        ST_FILL,
        ST_PUTWORD,
        ST_PUTDESC,
        ST_REEVAL,
        ST_DRAIN
    } rxsg_state_e;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] count;
    } desc_word_t;

    // check value byte i, most significant first
    function automatic logic [7:0] chk_byte(input logic [31:0] v, input logic [1:0] i);
        return v[8*(3-int'(i)) +: 8];
    endfunction

endpackage

// File: rtl/rxsg_sizer.sv
module rxsg_sizer #(
    parameter int LEN_W     = 12,
    parameter int SZ_W      = LEN_W + 1,
    parameter int MAX_STORE = 2032
) (
    input  logic [LEN_W-1:0] hdr_len,
    input  logic [15:0]      lim,
    output logic [SZ_W-1:0]  store_sz,
    output logic [SZ_W-1:0]  pay_cnt,
    output logic [LEN_W-1:0] tail_drop,
    output logic [15:0]      err_flags
);
    import rxsg_pkg::*;

    logic [SZ_W-1:0] raw_sz;
    logic            cut;
    logic            too_long;

    always_comb begin
        raw_sz    = SZ_W'(hdr_len) + SZ_W'(CHK_BYTES);
        cut       = 32'(raw_sz) > 32'(MAX_STORE);
        store_sz  = cut ? SZ_W'(MAX_STORE) : raw_sz;
        too_long  = cut || (32'(store_sz) > 32'(lim));
        pay_cnt   = store_sz - SZ_W'(CHK_BYTES);
        tail_drop = LEN_W'(SZ_W'(hdr_len) - pay_cnt);
        err_flags = '0;
        err_flags[FLG_TRUNC] = cut;
        err_flags[FLG_LONG]  = too_long;
    end

endmodule

// File: rtl/rxsg_packer.sv
module rxsg_packer (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        put,
    input  logic [1:0]  lane,
    input  logic [7:0]  din,
    output logic [31:0] word,
    output logic [3:0]  be
);
    // big-endian lanes: lane 0 lands in bits 31:24
    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] byte_q;
        logic       vld_q;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                byte_q <= '0;
                vld_q  <= 1'b0;
            end else if (put && lane == 2'(g)) begin
                byte_q <= din;
                vld_q  <= 1'b1;
            end
        end
        assign word[31-8*g -: 8] = byte_q;
        assign be[3-g]           = vld_q;
    end

endmodule

// File: rtl/rxsg_scatter.sv
module rxsg_scatter #(
    parameter int AW        = 32,
    parameter int LEN_W     = 12,
    parameter int BUF_W     = 11,
    parameter int MAX_STORE = 2032
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    ring_base,
    input  logic [BUF_W-1:0] buf_size,
    input  logic [15:0]      max_frm_len,
    input  logic             ring_init,
    input  logic             rx_arm,
    input  logic             hdr_valid,
    output logic             hdr_ready,
    input  logic [LEN_W-1:0] hdr_len,
    input  logic [31:0]      hdr_crc,
    input  logic             din_valid,
    output logic             din_ready,
    input  logic [7:0]       din_data,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    output logic [3:0]       mem_be,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             rx_active,
    output logic [AW-1:0]    cur_desc,
    output logic             ev_rx_buf,
    output logic             ev_rx_frame
);
    import rxsg_pkg::*;

    localparam int SZ_W = LEN_W + 1;
    localparam int CW   = (SZ_W > BUF_W) ? SZ_W : BUF_W;

    rxsg_state_e      state_q;
    logic [AW-1:0]    cur_q, walk_q, dptr_q;
    logic [SZ_W-1:0]  want_q, rem_q, sidx_q, pay_q, store_q;
    logic [LEN_W-1:0] len_q, drop_q, trdrop_q;
    logic [15:0]      err_q, dflags_q;
    logic [31:0]      crc_q;
    logic [BUF_W-1:0] nbuf_q, bofs_q;
    logic             active_q, evb_q, evf_q;

    logic [SZ_W-1:0]  sz_store, sz_pay;
    logic [LEN_W-1:0] sz_drop;
    logic [15:0]      sz_err;

    rxsg_sizer #(.LEN_W(LEN_W), .SZ_W(SZ_W), .MAX_STORE(MAX_STORE)) u_sizer (
        .hdr_len   (hdr_len),
        .lim       (max_frm_len),
        .store_sz  (sz_store),
        .pay_cnt   (sz_pay),
        .tail_drop (sz_drop),
        .err_flags (sz_err)
    );

    // byte source: payload from the stream, then the check value
    logic       from_pay, take;
    logic [7:0] fill_byte;
    logic [1:0] chk_idx;
    logic       pk_clr;
    logic [31:0] pk_word;
    logic [3:0]  pk_be;

    always_comb begin
        from_pay  = sidx_q < pay_q;
        chk_idx   = 2'(sidx_q - pay_q);
        fill_byte = from_pay ? din_data : chk_byte(crc_q, chk_idx);
        take      = (state_q == ST_FILL) && (!from_pay || din_valid);
        pk_clr    = (state_q == ST_PUTWORD) && mem_ack;
    end

    rxsg_packer u_packer (
        .clk  (clk),
        .rst  (rst),
        .clr  (pk_clr),
        .put  (take),
        .lane (bofs_q[1:0]),
        .din  (fill_byte),
        .word (pk_word),
        .be   (pk_be)
    );

    // derived quantities
    logic [CW-1:0]    rem_c, bs_c, want_c, nb_c;
    logic             last_buf, rd_empty, rd_wrap;
    logic [BUF_W-1:0] bofs_nx, wofs;
    logic [15:0]      new_flags;
    desc_word_t       wb_word;

    always_comb begin
        rem_c     = CW'(rem_q);
        bs_c      = CW'(buf_size);
        want_c    = CW'(want_q);
        nb_c      = (rem_c < bs_c) ? rem_c : bs_c;
        last_buf  = rem_c == CW'(nbuf_q);
        rd_empty  = mem_rdata[16 + FLG_EMPTY];
        rd_wrap   = mem_rdata[16 + FLG_WRAP];
        bofs_nx   = bofs_q + BUF_W'(1);
        wofs      = bofs_q - BUF_W'(1);
        new_flags = dflags_q;
        new_flags[FLG_EMPTY] = 1'b0;
        if (last_buf) begin
            new_flags = new_flags | err_q;
            new_flags[FLG_LAST] = 1'b1;
        end
        wb_word.flags = new_flags;
        wb_word.count = 16'(nbuf_q);
    end

    function automatic logic [AW-1:0] next_desc(input logic [AW-1:0] a, input logic wrap);
        return wrap ? ring_base : a + AW'(DESC_STRIDE);
    endfunction

    // memory port
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = walk_q;
        mem_wdata = '0;
        mem_be    = 4'hF;
        unique case (state_q)
            ST_ARM, ST_REEVAL: begin
                mem_req  = 1'b1;
                mem_addr = cur_q;
            end
            ST_CHECK, ST_GETFLG: mem_req = 1'b1;
            ST_GETPTR: begin
                mem_req  = 1'b1;
                mem_addr = walk_q + AW'(4);
            end
            ST_PUTWORD: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dptr_q + AW'({wofs[BUF_W-1:2], 2'b00});
                mem_wdata = pk_word;
                mem_be    = pk_be;
            end
            ST_PUTDESC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = wb_word;
            end
            default: ;
        endcase
    end

    assign hdr_ready   = (state_q == ST_IDLE) && !ring_init && !rx_arm;
    assign din_ready   = ((state_q == ST_FILL) && from_pay) || (state_q == ST_DRAIN);
    assign rx_active   = active_q;
    assign cur_desc    = cur_q;
    assign ev_rx_buf   = evb_q;
    assign ev_rx_frame = evf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cur_q    <= '0;
            walk_q   <= '0;
            dptr_q   <= '0;
            want_q   <= '0;
            rem_q    <= '0;
            sidx_q   <= '0;
            pay_q    <= '0;
            store_q  <= '0;
            len_q    <= '0;
            drop_q   <= '0;
            trdrop_q <= '0;
            err_q    <= '0;
            dflags_q <= '0;
            crc_q    <= '0;
            nbuf_q   <= '0;
            bofs_q   <= '0;
            active_q <= 1'b0;
            evb_q    <= 1'b0;
            evf_q    <= 1'b0;
        end else begin
            evb_q <= 1'b0;
            evf_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (ring_init) begin
                        cur_q    <= ring_base;
                        active_q <= 1'b0;
                    end else if (rx_arm) begin
                        if (!active_q) state_q <= ST_ARM;
                    end else if (hdr_valid) begin
                        len_q    <= hdr_len;
                        crc_q    <= hdr_crc;
                        store_q  <= sz_store;
                        pay_q    <= sz_pay;
                        trdrop_q <= sz_drop;
                        err_q    <= sz_err;
                        want_q   <= sz_store;
                        walk_q   <= cur_q;
                        if (!active_q) begin
                            drop_q  <= hdr_len;
                            state_q <= (hdr_len != '0) ? ST_DRAIN : ST_IDLE;
                        end else begin
                            state_q <= ST_CHECK;
                        end
                    end
                end
                ST_ARM: if (mem_ack) begin
                    active_q <= rd_empty;
                    state_q  <= ST_IDLE;
                end
                ST_CHECK: if (mem_ack) begin
                    if (!rd_empty) begin
                        drop_q  <= len_q;
                        state_q <= (len_q != '0) ? ST_DRAIN : ST_IDLE;
                    end else if (want_c < bs_c) begin
                        walk_q  <= cur_q;
                        rem_q   <= store_q;
                        sidx_q  <= '0;
                        drop_q  <= trdrop_q;
                        state_q <= ST_GETFLG;
                    end else begin
                        want_q <= SZ_W'(want_c - bs_c);
                        walk_q <= next_desc(walk_q, rd_wrap);
                    end
                end
                ST_GETFLG: if (mem_ack) begin
                    dflags_q <= mem_rdata[31:16];
                    state_q  <= ST_GETPTR;
                end
                ST_GETPTR: if (mem_ack) begin
                    dptr_q  <= AW'(mem_rdata) & ~AW'(3);
                    nbuf_q  <= BUF_W'(nb_c);
                    bofs_q  <= '0;
                    state_q <= ST_FILL;
                end
                ST_FILL: if (take) begin
                    sidx_q <= sidx_q + SZ_W'(1);
                    bofs_q <= bofs_nx;
                    if (bofs_q[1:0] == 2'd3 || bofs_nx == nbuf_q) state_q <= ST_PUTWORD;
                end
                ST_PUTWORD: if (mem_ack) begin
                    state_q <= (bofs_q == nbuf_q) ? ST_PUTDESC : ST_FILL;
                end
                ST_PUTDESC: if (mem_ack) begin
                    evf_q  <= last_buf;
                    evb_q  <= !last_buf;
                    rem_q  <= rem_q - SZ_W'(nbuf_q);
                    walk_q <= next_desc(walk_q, dflags_q[FLG_WRAP]);
                    if (last_buf) begin
                        cur_q   <= next_desc(walk_q, dflags_q[FLG_WRAP]);
                        state_q <= ST_REEVAL;
                    end else begin
                        state_q <= ST_GETFLG;
                    end
                end
                ST_REEVAL: if (mem_ack) begin
                    active_q <= rd_empty;
                    state_q  <= (drop_q != '0) ? ST_DRAIN : ST_IDLE;
                end
                ST_DRAIN: if (din_valid) begin
                    drop_q <= drop_q - LEN_W'(1);
                    if (drop_q == LEN_W'(1)) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R12: a stalled request keeps its address and direction
    a_r12_req_held: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R9: a frame event follows an accepted write carrying the last flag
    a_r9_frame_after_last: assert property (@(posedge clk) disable iff (rst)
        ev_rx_frame |-> $past(mem_req && mem_we && mem_ack && mem_wdata[16 + FLG_LAST]));

    // R9: a buffer event follows a non-last write-back with empty cleared
    a_r9_buf_not_last: assert property (@(posedge clk) disable iff (rst)
        ev_rx_buf |-> $past(mem_req && mem_we && mem_ack
                            && !mem_wdata[16 + FLG_LAST] && !mem_wdata[16 + FLG_EMPTY]));

    // R11: arming only follows a completed read that saw the empty bit
    a_r11_arm_from_read: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_active) |-> $past(mem_req && mem_ack && !mem_we && mem_rdata[16 + FLG_EMPTY]));

    // R7: every data word write enables at least one byte
    a_r7_data_be: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PUTWORD) |-> mem_be != 4'h0);

    // R13: discarding never runs past the announced bytes
    a_r13_drain_bounded: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN) |-> drop_q != '0);

endmodule

// File: tb/test_rxsg_scatter.sv
`timescale 1ns/1ps
module test_rxsg_scatter;

    localparam int MS = 40;
    localparam int BS = 16;

    logic        clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst = 1'b1;
    logic [31:0] ring_base = '0;
    logic [10:0] buf_size = 11'(BS);
    logic [15:0] lim = 16'hFFFF;
    logic        ring_init = 1'b0, rx_arm = 1'b0;
    logic        hdr_valid = 1'b0, hdr_ready;
    logic [11:0] hdr_len = '0;
    logic [31:0] hdr_crc = '0;
    logic        din_valid = 1'b0, din_ready;
    logic [7:0]  din_data = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        rx_active, ev_rx_buf, ev_rx_frame;
    logic [31:0] cur_desc;

    rxsg_scatter #(.MAX_STORE(MS)) i_rxsg_scatter (
        .clk(clk), .rst(rst), .ring_base(ring_base), .buf_size(buf_size),
        .max_frm_len(lim), .ring_init(ring_init), .rx_arm(rx_arm),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_len(hdr_len), .hdr_crc(hdr_crc),
        .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rx_active(rx_active), .cur_desc(cur_desc),
        .ev_rx_buf(ev_rx_buf), .ev_rx_frame(ev_rx_frame)
    );

    // memory model: 128 words, descriptors at 0x00, buffers at 0x100
    logic [31:0] mem [0:127];
    logic        hw_en = 1'b0;
    logic [6:0]  hw_idx = '0;
    logic [31:0] hw_dat = '0;
    logic [7:0]  lf = 8'h01;

    assign mem_rdata = mem[mem_addr[8:2]];
    assign mem_ack   = lf[0] | lf[2];

    always @(negedge clk) lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};

    always @(posedge clk) begin
        if (hw_en) mem[hw_idx] <= hw_dat;
        else if (mem_req && mem_we && mem_ack)
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[8:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end

    // monitors
    logic        cnt_clr = 1'b0;
    int          n_buf, n_frm, n_wr, n_acc, hold_bad, rdy_bad;
    logic        prev_wait;
    logic [31:0] prev_addr;
    initial begin n_buf = 0; n_frm = 0; n_wr = 0; n_acc = 0; hold_bad = 0; rdy_bad = 0; prev_wait = 0; prev_addr = 0; end

    always @(posedge clk) begin
        if (cnt_clr) begin
            n_buf <= 0; n_frm <= 0; n_wr <= 0; n_acc <= 0;
        end else begin
            if (ev_rx_buf) n_buf <= n_buf + 1;
            if (ev_rx_frame) n_frm <= n_frm + 1;
            if (mem_req && mem_we && mem_ack) n_wr <= n_wr + 1;
            if (din_valid && din_ready) n_acc <= n_acc + 1;
        end
        if (!rst && prev_wait && (!mem_req || mem_addr != prev_addr)) hold_bad <= hold_bad + 1;
        if (!rst && din_ready && hdr_ready) rdy_bad <= rdy_bad + 1;
        prev_wait <= !rst && mem_req && !mem_ack;
        prev_addr <= mem_addr;
    end

    int total = 0, bad = 0;
    int m_cur = 0;
    bit m_active = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input int idx, input logic [31:0] d);
        hw_en = 1'b1; hw_idx = 7'(idx); hw_dat = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    // mask bit set = descriptor not empty
    task automatic setup(input logic [3:0] mask);
        for (int i = 0; i < 4; i++) begin
            logic [15:0] f;
            f = '0;
            f[15] = !mask[i];
            f[13] = (i == 3);
            host_wr(2*i, {f, 16'h0});
            host_wr(2*i + 1, 32'h100 + 32'(16*i));
            for (int w = 0; w < 4; w++) host_wr(64 + 4*i + w, 32'hA5A5A5A5);
        end
    endtask

    task automatic wait_idle();
        while (!hdr_ready) @(negedge clk);
    endtask

    task automatic pulse_init();
        ring_init = 1'b1; @(negedge clk); ring_init = 1'b0; wait_idle();
    endtask

    task automatic pulse_arm();
        rx_arm = 1'b1; @(negedge clk); rx_arm = 1'b0;
        @(negedge clk); wait_idle();
    endtask

    function automatic logic [7:0] pbyte(input int len, input int k);
        return 8'((k * 7 + len * 13 + 1) & 255);
    endfunction

    function automatic logic [31:0] crcv(input int len);
        return 32'hC0DE1234 ^ (32'(len) * 32'h01010101);
    endfunction

    task automatic send_frame(input int len);
        hdr_valid = 1'b1; hdr_len = 12'(len); hdr_crc = crcv(len);
        while (1) begin
            if (hdr_ready) begin @(posedge clk); @(negedge clk); break; end
            @(negedge clk);
        end
        hdr_valid = 1'b0;
        for (int k = 0; k < len; k++) begin
            din_valid = 1'b1; din_data = pbyte(len, k);
            while (1) begin
                if (din_ready) begin @(posedge clk); @(negedge clk); break; end
                @(negedge clk);
            end
        end
        din_valid = 1'b0;
        @(negedge clk);
        wait_idle();
        @(negedge clk);
    endtask

    task automatic run_frame(input int len, input logic [3:0] mask);
        int size, pay, want, k, nd;
        bit tr, lg, space;
        setup(mask);
        cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
        send_frame(len);
        size = len + 4;
        tr = size > MS;
        if (tr) size = MS;
        lg = tr || (size > int'(lim));
        pay = size - 4;
        space = 0; want = size; k = m_cur;
        for (int s = 0; s < 8; s++) begin
            if (mask[k]) break;
            if (want < BS) begin space = 1; break; end
            want -= BS; k = (k + 1) % 4;
        end
        chk(n_acc == len, "R4 R13 bytes consumed", 32'(n_acc), 32'(len));
        if (!m_active) begin
            chk(n_wr == 0 && n_buf == 0 && n_frm == 0, "R3 inactive no write", 32'(n_wr), 0);
            chk(cur_desc == 32'(8*m_cur), "R3 pointer kept", cur_desc, 32'(8*m_cur));
        end else if (!space) begin
            chk(n_wr == 0 && n_buf == 0 && n_frm == 0, "R6 rejected no write", 32'(n_wr), 0);
            chk(cur_desc == 32'(8*m_cur), "R6 pointer kept", cur_desc, 32'(8*m_cur));
        end else begin
            nd = (size + BS - 1) / BS;
            for (int d = 0; d < nd; d++) begin
                int i, n;
                logic [15:0] f;
                i = (m_cur + d) % 4;
                n = (size - BS*d < BS) ? size - BS*d : BS;
                f = '0;
                f[13] = (i == 3);
                if (d == nd - 1) begin f[11] = 1'b1; f[0] = tr; f[5] = lg; end
                chk(mem[2*i] == {f, 16'(n)}, "R4 R5 R9 descriptor word", mem[2*i], {f, 16'(n)});
                for (int w = 0; w < 4; w++) begin
                    logic [31:0] ew;
                    for (int l = 0; l < 4; l++) begin
                        int j, g;
                        logic [7:0] eb;
                        j = 4*w + l; g = BS*d + j;
                        if (j >= n) eb = 8'hA5;
                        else if (g < pay) eb = pbyte(len, g);
                        else eb = crcv(len)[8*(3-(g-pay)) +: 8];
                        ew[31-8*l -: 8] = eb;
                    end
                    chk(mem[64 + 4*i + w] == ew, "R7 R8 buffer word", mem[64 + 4*i + w], ew);
                end
            end
            chk(n_buf == nd - 1, "R9 buffer events", 32'(n_buf), 32'(nd - 1));
            chk(n_frm == 1, "R9 frame events", 32'(n_frm), 1);
            m_cur = (m_cur + nd) % 4;
            chk(cur_desc == 32'(8*m_cur), "R10 pointer advance", cur_desc, 32'(8*m_cur));
            m_active = !mask[m_cur];
            chk(rx_active == m_active, "R11 re-armed", 32'(rx_active), 32'(m_active));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rx_active == 0, "R1 inactive", 32'(rx_active), 0);
        chk(cur_desc == 0, "R1 pointer", cur_desc, 0);
        chk(mem_req == 0, "R1 no request", 32'(mem_req), 0);
        chk(hdr_ready && !din_ready, "R1 R13 ready levels", {hdr_ready, din_ready}, 32'h2);

        setup(4'b0000);
        pulse_init();
        chk(cur_desc == 0 && !rx_active, "R2 ring init", cur_desc, 0);
        run_frame(10, 4'b0000);

        setup(4'b0001);
        pulse_arm();
        chk(rx_active == 0, "R2 arm on full descriptor", 32'(rx_active), 0);
        setup(4'b0000);
        pulse_arm();
        m_active = 1;
        chk(rx_active == 1, "R2 arm on empty descriptor", 32'(rx_active), 1);

        lim = 16'hFFFF;
        for (int len = 0; len < 46; len++) run_frame(len, 4'b0000);
        lim = 16'd20;
        for (int len = 0; len < 46; len++) run_frame(len, 4'b0000);
        lim = 16'hFFFF;

        // R6: next descriptor full -> two-buffer frame and exact-size frame rejected
        run_frame(20, 4'(1 << ((m_cur + 1) % 4)));
        run_frame(12, 4'(1 << ((m_cur + 1) % 4)));
        // one-buffer frame accepted, then ring hits the full descriptor (R11)
        run_frame(11, 4'(1 << ((m_cur + 1) % 4)));
        run_frame(5, 4'b0000);

        setup(4'b0000);
        pulse_init();
        m_cur = 0; m_active = 0;
        chk(cur_desc == 0, "R2 reload from ring base", cur_desc, 0);
        pulse_arm();
        m_active = 1;
        run_frame(30, 4'b0000);

        chk(hold_bad == 0, "R12 request held", 32'(hold_bad), 0);
        chk(rdy_bad == 0, "R13 ready exclusive", 32'(rdy_bad), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule